// File: doc/BRIEF.md
# Command-Word Watchdog Timer

This block is a watchdog built on a 20-bit down-counter that advances on a slow tick strobe supplied from outside. Software controls it through two word-aligned registers on a simple synchronous bus. The control register, at byte offset 0x00, acts only on a small set of 16-bit command words. The count register, at byte offset 0x04, shows the upper 16 bits of the counter. Software can write the count register only after it has opened a write window with an unlock command.

When the counter runs down to zero, the block sets a sticky interrupt flag and emits a one-cycle reset-request pulse. The counter then stays at zero until software loads it again. Software keeps the system alive by reloading the counter before it expires. It can force a near-immediate expiry, as a software restart, by loading a count of one and resuming.

Top module: `cmdword_wdt`

## Requirements
- R1: After reset the counter is stopped and holds 0xFFFFF, so a count read returns 0xFFFF. The count register is locked, `irq` is 0 and `rst_req` is 0.
- R2: Writing control word 0x3877 stops counting, and ticks then leave the count unchanged. Writing 0x4A4B lets counting go on from the held value.
- R3: Writing control word 0x7482 clears `irq`.
- R4: Control word 0xAB00 opens the count register for writes and 0xAB01 closes it. A count write while the register is closed leaves the counter unchanged.
- R5: Control word 0xDEAF sets the counter to 0xFFFFF at any time, whether the count register is open or closed and whether the counter is running or stopped.
- R6: The counter drops by exactly one on a cycle where it is running, `tick_en` is 1 and the count is nonzero. On any other cycle it does not change by itself.
- R7: A count write while the register is open loads counter bits [19:4] from `bus_wdata[15:0]` and sets bits [3:0] to 0xF. A read of offset 0x04 returns counter bits [19:4] in `bus_rdata[15:0]`, with the upper bits 0, one cycle after `bus_re`. Any other read returns 0.
- R8: The tick that takes the running counter from 1 to 0 sets `irq` and makes `rst_req` high for exactly one cycle. Both outputs change on the same edge that the count reaches zero.
- R9: Once it is at zero, the counter stays there and makes no further `rst_req` pulse or `irq` setting until it is reloaded.
- R10: A control write whose low 16 bits match none of the six command words has no effect, and neither has a write to any offset other than 0x00 or 0x04.
- R11: The sequence stop, unlock, write count 1, lock, resume loads 0x0001F and expires on the 31st tick after it.
- R12: When a count load or a reload-to-maximum falls on the same cycle as a tick, the loaded value wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timebase strobe |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on expiry |
| irq | output | 1 | Sticky expiry interrupt flag |

## Verification
A wrong run flag shows up on the first count read that follows 16 ticks, because the visible upper count bits either move when they should hold or hold when they should move. A lock flag in the wrong state shows on the very next count read after a count write. An off-by-one in the decrement or in the loaded low nibble moves the expiry pulse by a whole tick period, and the bench catches this by counting ticks to the `rst_req` edge exactly. Counter state that leaves zero on its own, or a pulse that lasts too long, shows as extra `rst_req` cycles in a running pulse count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DEF_ADDR_W = 4;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_CNT_W  = 20;
    localparam int DEF_REG_W  = 16;

    localparam int OFS_CTRL = 0;
    localparam int OFS_CNT  = 4;

    localparam logic [15:0] WORD_HALT = 16'h3877;
    localparam logic [15:0] WORD_RUN  = 16'h4A4B;
    localparam logic [15:0] WORD_ACK  = 16'h7482;
    localparam logic [15:0] WORD_OPEN = 16'hAB00;
    localparam logic [15:0] WORD_SEAL = 16'hAB01;
    localparam logic [15:0] WORD_FILL = 16'hDEAF;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_HALT,
        OP_RUN,
        OP_ACK,
        OP_OPEN,
        OP_SEAL,
        OP_FILL
    } op_e;

    typedef struct packed {
        logic running;
        logic unlocked;
    } mode_t;

    function automatic op_e decode_op(input logic [15:0] word);
        op_e res;
        case (word)
            WORD_HALT: res = OP_HALT;
            WORD_RUN:  res = OP_RUN;
            WORD_ACK:  res = OP_ACK;
            WORD_OPEN: res = OP_OPEN;
            WORD_SEAL: res = OP_SEAL;
            WORD_FILL: res = OP_FILL;
            default:   res = OP_NONE;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/wdt_bus_if.sv
module wdt_bus_if
    import wdt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int REG_W  = DEF_REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    input  logic [REG_W-1:0]  cnt_hi,
    output op_e               op,
    output logic              load_req,
    output logic [REG_W-1:0]  load_val,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

    logic [DATA_W-1:0] rd_next;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

    always_comb begin
        op       = OP_NONE;
        load_req = 1'b0;
        if (bus_we) begin
            if (bus_addr == A_CTRL) begin
                op = decode_op(bus_wdata[15:0]);
            end else if (bus_addr == A_CNT) begin
                load_req = 1'b1;
            end
        end
    end

    assign load_val = bus_wdata[REG_W-1:0];

    always_comb begin
        rd_next = '0;
        if (bus_re && bus_addr == A_CNT) begin
            rd_next[REG_W-1:0] = cnt_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/wdt_mode_ctl.sv
module wdt_mode_ctl
    import wdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  logic  load_req,
    input  logic  expire,
    output mode_t mode_q,
    output logic  load_en,
    output logic  fill_en,
    output logic  irq_q,
    output logic  rst_req_q
);

    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        case (op)
            OP_HALT: mode_d.running  = 1'b0;
            OP_RUN:  mode_d.running  = 1'b1;
            OP_OPEN: mode_d.unlocked = 1'b1;
            OP_SEAL: mode_d.unlocked = 1'b0;
            default: ;
        endcase
    end

    assign load_en = load_req & mode_q.unlocked;
    assign fill_en = (op == OP_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            irq_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            rst_req_q <= expire;
            if (expire) begin
                irq_q <= 1'b1;
            end else if (op == OP_ACK) begin
                irq_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int REG_W = DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [REG_W-1:0] load_val,
    input  logic             fill_en,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);

    localparam int               LOW_W = CNT_W - REG_W;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic step;

    assign step   = running && tick_en && (count_q != '0);
    assign expire = step && (count_q == ONE) && !load_en && !fill_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '1;
        end else if (fill_en) begin
            count_q <= '1;
        end else if (load_en) begin
            count_q <= {load_val, {LOW_W{1'b1}}};
        end else if (step) begin
            count_q <= count_q - ONE;
        end
    end

endmodule

// File: rtl/cmdword_wdt.sv
module cmdword_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int REG_W  = DEF_REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              irq
);

    op_e              op;
    logic             load_req;
    logic [REG_W-1:0] load_val;
    mode_t            mode_q;
    logic             load_en;
    logic             fill_en;
    logic             expire;
    logic [CNT_W-1:0] count_q;
    logic             running_q;
    logic             unlocked_q;

    assign running_q  = mode_q.running;
    assign unlocked_q = mode_q.unlocked;

    wdt_bus_if #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .REG_W (REG_W)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_re   (bus_re),
        .cnt_hi   (count_q[CNT_W-1:CNT_W-REG_W]),
        .op       (op),
        .load_req (load_req),
        .load_val (load_val),
        .bus_rdata(bus_rdata)
    );

    wdt_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_req (load_req),
        .expire   (expire),
        .mode_q   (mode_q),
        .load_en  (load_en),
        .fill_en  (fill_en),
        .irq_q    (irq),
        .rst_req_q(rst_req)
    );

    wdt_down_counter #(
        .CNT_W(CNT_W),
        .REG_W(REG_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .running (running_q),
        .tick_en (tick_en),
        .load_en (load_en),
        .load_val(load_val),
        .fill_en (fill_en),
        .count_q (count_q),
        .expire  (expire)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rst_req,
    input logic              irq,
    input logic [CNT_W-1:0]  count_q,
    input logic              running_q,
    input logic              unlocked_q
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !bus_we) |=> $stable(count_q)); // R2

    AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CNT && !unlocked_q
         && !(running_q && tick_en && count_q != '0)) |=> $stable(count_q)); // R4

    AST_FILL_SETS_MAX: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CTRL && bus_wdata[15:0] == WORD_FILL) |=> (count_q == '1)); // R5

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (running_q && tick_en && count_q != '0 && !bus_we) |=> (count_q == $past(count_q) - ONE)); // R6

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R8

    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (irq && count_q == '0)); // R8

    AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && !bus_we) |=> (count_q == '0 && !rst_req)); // R9

endmodule

bind cmdword_wdt wdt_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_wdt_checker (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rst_req   (rst_req),
    .irq       (irq),
    .count_q   (count_q),
    .running_q (running_q),
    .unlocked_q(unlocked_q)
);

// File: tb/test_cmdword_wdt.sv
`timescale 1ns/1ps
module test_cmdword_wdt;

    localparam logic [31:0] C_HALT = 32'h3877;
    localparam logic [31:0] C_RUN  = 32'h4A4B;
    localparam logic [31:0] C_ACK  = 32'h7482;
    localparam logic [31:0] C_OPEN = 32'hAB00;
    localparam logic [31:0] C_SEAL = 32'hAB01;
    localparam logic [31:0] C_FILL = 32'hDEAF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    cmdword_wdt i_cmdword_wdt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata),
        .rst_req  (rst_req),
        .irq      (irq)
    );

    always @(negedge clk) if (!rst && rst_req) pulses++;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1", "irq after reset", 32'(irq), 32'd0);
        check("R1", "rst_req after reset", 32'(rst_req), 32'd0);
        rd(4'h4, v); check("R1", "count after reset", v, 32'hFFFF);
        rd(4'h0, v); check("R7", "control read", v, 32'h0);
        tick(3);
        rd(4'h4, v); check("R1", "stopped after reset", v, 32'hFFFF);
        wr(4'h4, 32'h1234);
        rd(4'h4, v); check("R1", "locked after reset", v, 32'hFFFF);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(4'h0, C_OPEN);
        wr(4'h4, 32'h1234);
        rd(4'h4, v); check("R7", "count load", v, 32'h1234);
        wr(4'h4, 32'hABCD_0042);
        rd(4'h4, v); check("R7", "upper write bits ignored", v, 32'h0042);
        wr(4'h0, C_SEAL);
        wr(4'h4, 32'h5555);
        rd(4'h4, v); check("R4", "write while locked", v, 32'h0042);
        wr(4'h0, C_OPEN);
        wr(4'h4, 32'h0002);
        rd(4'h4, v); check("R4", "write after reopen", v, 32'h0002);
    endtask

    task automatic t_decrement();
        logic [31:0] v;
        wr(4'h0, C_RUN);
        tick(15);
        rd(4'h4, v); check("R7", "low nibble loaded as F", v, 32'h0002);
        tick(1);
        rd(4'h4, v); check("R6", "sixteenth tick", v, 32'h0001);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int p0;
        p0 = pulses;
        wr(4'h0, C_HALT);
        tick(20);
        rd(4'h4, v); check("R2", "stopped holds", v, 32'h0001);
        wr(4'h0, C_RUN);
        tick(16);
        rd(4'h4, v); check("R2", "resume continues", v, 32'h0000);
        check("R2", "no pulse", 32'(pulses - p0), 32'd0);
    endtask

    task automatic t_fill();
        logic [31:0] v;
        wr(4'h0, C_SEAL);
        wr(4'h0, C_HALT);
        wr(4'h0, C_FILL);
        rd(4'h4, v); check("R5", "fill while locked", v, 32'hFFFF);
        wr(4'h0, C_RUN);
        tick(16);
        rd(4'h4, v); check("R6", "decrement from max", v, 32'hFFFE);
        wr(4'h0, C_FILL);
        rd(4'h4, v); check("R5", "fill while running", v, 32'hFFFF);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(4'h0, C_OPEN);
        @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'h5; bus_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        tick(15);
        rd(4'h4, v); check("R12", "load beats tick", v, 32'h0005);
        tick(1);
        rd(4'h4, v); check("R12", "next step", v, 32'h0004);
    endtask

    task automatic t_expiry();
        logic [31:0] v;
        int p0;
        wr(4'h4, 32'h0);
        wr(4'h0, C_SEAL);
        p0 = pulses;
        tick(14);
        check("R8", "no early pulse", 32'(pulses - p0), 32'd0);
        check("R8", "no early irq", 32'(irq), 32'd0);
        tick(1);
        check("R8", "rst_req on expiry", 32'(rst_req), 32'd1);
        check("R8", "irq on expiry", 32'(irq), 32'd1);
        @(negedge clk);
        check("R8", "rst_req drops", 32'(rst_req), 32'd0);
        check("R8", "single pulse", 32'(pulses - p0), 32'd1);
        tick(5);
        check("R9", "no repeat pulse", 32'(pulses - p0), 32'd1);
        rd(4'h4, v); check("R9", "holds zero", v, 32'h0);
        wr(4'h0, C_ACK);
        check("R3", "irq cleared", 32'(irq), 32'd0);
        tick(3);
        check("R9", "irq stays clear", 32'(irq), 32'd0);
    endtask

    task automatic t_unknown();
        logic [31:0] v;
        logic [31:0] junk [7] = '{32'h3876, 32'h4A4A, 32'hAB02, 32'hAB10, 32'hDEAE, 32'h0000, 32'hFFFF};
        wr(4'h0, C_HALT);
        wr(4'h0, C_OPEN);
        wr(4'h4, 32'h0003);
        wr(4'h0, C_SEAL);
        foreach (junk[i]) wr(4'h0, junk[i]);
        wr(4'h8, C_OPEN);
        wr(4'hC, C_RUN);
        tick(20);
        rd(4'h4, v); check("R10", "still stopped", v, 32'h0003);
        wr(4'h4, 32'h7777);
        rd(4'h4, v); check("R10", "still locked", v, 32'h0003);
        rd(4'h8, v); check("R7", "unmapped read", v, 32'h0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        int p0;
        wr(4'h0, C_HALT);
        wr(4'h0, C_OPEN);
        wr(4'h4, 32'h1);
        wr(4'h0, C_SEAL);
        wr(4'h0, C_RUN);
        p0 = pulses;
        tick(30);
        check("R11", "not yet expired", 32'(pulses - p0), 32'd0);
        tick(1);
        check("R11", "expiry on 31st tick", 32'(rst_req), 32'd1);
        check("R11", "irq set", 32'(irq), 32'd1);
        wr(4'h4, 32'h9);
        rd(4'h4, v); check("R11", "left locked", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock();
        t_decrement();
        t_stop();
        t_fill();
        t_collide();
        t_expiry();
        t_unknown();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..R12 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule